// File: doc/BRIEF.md
# Command-Addressed Endpoint Packet Buffer

This block is the packet store of a USB device controller as a host processor sees it over a 16-bit parallel bus. One address line (`bus_cmd`) separates the two kinds of cycle. In a command cycle the processor writes a code on the low byte, and that code selects an endpoint and an operation. In a data cycle the processor moves a full 16-bit word to or from the selected buffer. By convention a buffer holds a packet-length word first, followed by the payload packed two bytes per word. The block stores these words as they are written and does not interpret them.

The device side reaches the same storage through a simple fill port and a drain port. The fill port writes words and then reports that a packet is complete. The drain port reads any word combinationally. Each endpoint keeps an interrupt flag, a stall bit and a setup-seen bit, and a status command returns them. Pointers are not bounds-checked. During DMA on a double-buffered endpoint, the pointer moves from the end of the primary half into the secondary half.

The command sequencer has four states: `ST_IDLE` (no buffer selected), `ST_WRBUF` (write armed), `ST_RDBUF` (read armed) and `ST_STAT` (status armed). Every command cycle enters one of these states according to its code group. A write-data cycle in `ST_WRBUF` stores a word and advances the pointer. A read-data cycle in `ST_RDBUF` advances the pointer. A read-data cycle in `ST_STAT` clears the flags and returns to `ST_IDLE`. Every other data cycle leaves the state unchanged.

Top module: `epb_bank`

## Requirements
- R1: A command cycle is `bus_cs=1, bus_cmd=1, bus_wr=1`. Bits [15:8] of the data are ignored. Bits [7:4] select the group: 0h writes endpoint buffer n, 1h reads endpoint buffer n, 5h returns the status of endpoint n, 4h stalls endpoint n and 8h unstalls it. Bits [3:0] give n. Any other group returns the sequencer to idle.
- R2: The first data cycle after a buffer command accesses word index 0, which holds the length word N. Each following data cycle accesses the next index.
- R3: The payload starts at index 1. Word k holds byte 2k-1 in bits [7:0] and byte 2k in bits [15:8]. The payload takes (N+1)/2 words, and the block returns every stored word exactly as written.
- R4: Every command cycle resets the data pointer to index 0.
- R5: A data cycle with no valid buffer or status command before it, or with the wrong direction for the armed command, changes no storage. `bus_rdata` is 0 except during a read-data cycle in the read or status state.
- R6: Outside DMA, or on a single-buffered endpoint, the pointer wraps from index HALF_WORDS-1 to index 0 of the same half. No error is signalled.
- R7: With `bus_dma=1` on a double-buffered endpoint (bit set in DBL_MASK), the access after primary index HALF_WORDS-1 goes to the secondary half at index 0, which is word HALF_WORDS of the region. The end of the secondary half wraps back to primary index 0.
- R8: `fill_done` together with `fill_ok` sets the interrupt flag of `fill_ep`. `fill_done` without `fill_ok` leaves the flag unchanged.
- R9: Status word bits: [0] interrupt flag, [1] stall, [2] setup seen, [3] double-buffered; all other bits are 0. A status read clears the interrupt flag and the setup-seen bit, but a set in the same cycle wins. After a status read the sequencer is idle.
- R10: A stall command sets the stall bit and an unstall command clears it. `setup_rx` clears the stall bit of `setup_ep` and sets its setup-seen bit.
- R11: `irq` is high while any endpoint's interrupt flag is set.
- R12: After reset all flags are 0, `irq` is 0 and the sequencer is idle.
- R13: The drain port returns the word at index `drn_idx` of endpoint `drn_ep` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus cycle valid |
| bus_cmd | input | 1 | 1 = command cycle, 0 = data cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_dma | input | 1 | Current data cycle is a DMA access |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data (combinational) |
| fill_we | input | 1 | Device-side word write |
| fill_ep | input | EW | Fill endpoint |
| fill_idx | input | PW+1 | Fill word index (bit PW selects the half) |
| fill_wdata | input | 16 | Fill word |
| fill_done | input | 1 | Packet complete strobe |
| fill_ok | input | 1 | Packet received without error |
| drn_ep | input | EW | Drain endpoint |
| drn_idx | input | PW+1 | Drain word index |
| drn_rdata | output | 16 | Drain word |
| setup_rx | input | 1 | SETUP token received |
| setup_ep | input | EW | Endpoint of the SETUP token |
| irq | output | 1 | Any interrupt flag set |

## Verification
The in-line assertions check on every cycle that a command returns the pointer to index 0 and that an idle data cycle moves neither the pointer nor the state. They also check the wrap within one half and the DMA step into the secondary half, the return to idle after a status read, the clearing of flags by a status read, setting by a fill and clearing of stall by SETUP, and that `bus_rdata` is quiet when idle. The data itself can only be shown by the bench's scenarios: byte order in the payload words, odd-length packets, what ends up at which index after an overrun, the precedence of a set over a clear, and the round trip of random packets between the bus and the device-side ports.

// File: rtl/epb_pkg.sv
package epb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRBUF = 2'd1,
        ST_RDBUF = 2'd2,
        ST_STAT  = 2'd3
    } epb_state_e;

    localparam logic [3:0] GRP_WR      = 4'h0;
    localparam logic [3:0] GRP_RD      = 4'h1;
    localparam logic [3:0] GRP_STALL   = 4'h4;
    localparam logic [3:0] GRP_STAT    = 4'h5;
    localparam logic [3:0] GRP_UNSTALL = 4'h8;

    localparam int SB_INT   = 0;
    localparam int SB_STALL = 1;
    localparam int SB_SETUP = 2;
    localparam int SB_DBL   = 3;

endpackage

// File: rtl/epb_cmd_fsm.sv
module epb_cmd_fsm
    import epb_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int HALF_WORDS = 32,
    parameter logic [NUM_EP-1:0] DBL_MASK = '0,
    localparam int EW = $clog2(NUM_EP),
    localparam int PW = $clog2(HALF_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_cmd,
    input  logic          bus_wr,
    input  logic          bus_dma,
    input  logic [15:0]   bus_wdata,
    output epb_state_e    state,
    output logic [EW-1:0] sel_ep,
    output logic [PW:0]   ptr,
    output logic [EW-1:0] cmd_ep,
    output logic          mem_we,
    output logic          stat_rd,
    output logic          stall_set,
    output logic          stall_clr
);

    localparam logic [PW:0] LAST_PRI  = {1'b0, {PW{1'b1}}};
    localparam logic [PW:0] FIRST_SEC = {1'b1, {PW{1'b0}}};

    epb_state_e    state_n;
    logic [PW:0]   ptr_n;
    logic [EW-1:0] ep_n;
    logic          step;
    logic          cmd_fire, data_wr, data_rd, roll;
    logic [3:0]    grp;

    assign cmd_fire = bus_cs & bus_cmd & bus_wr;
    assign data_wr  = bus_cs & ~bus_cmd & bus_wr;
    assign data_rd  = bus_cs & ~bus_cmd & ~bus_wr;
    assign grp      = bus_wdata[7:4];
    assign cmd_ep   = bus_wdata[EW-1:0];
    assign roll     = bus_dma & DBL_MASK[sel_ep];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            sel_ep <= '0;
        end else begin
            state  <= state_n;
            ptr    <= ptr_n;
            sel_ep <= ep_n;
        end
    end

    always_comb begin
        state_n   = state;
        ptr_n     = ptr;
        ep_n      = sel_ep;
        mem_we    = 1'b0;
        stat_rd   = 1'b0;
        stall_set = 1'b0;
        stall_clr = 1'b0;
        step      = 1'b0;
        if (cmd_fire) begin
            ptr_n = '0;
            ep_n  = cmd_ep;
            unique case (grp)
                GRP_WR:      state_n = ST_WRBUF;
                GRP_RD:      state_n = ST_RDBUF;
                GRP_STAT:    state_n = ST_STAT;
                GRP_STALL: begin
                    state_n   = ST_IDLE;
                    stall_set = 1'b1;
                end
                GRP_UNSTALL: begin
                    state_n   = ST_IDLE;
                    stall_clr = 1'b1;
                end
                default:     state_n = ST_IDLE;
            endcase
        end else begin
            unique case (state)
                ST_IDLE:  ;
                ST_WRBUF: if (data_wr) begin
                    mem_we = 1'b1;
                    step   = 1'b1;
                end
                ST_RDBUF: if (data_rd) step = 1'b1;
                ST_STAT:  if (data_rd) begin
                    stat_rd = 1'b1;
                    state_n = ST_IDLE;
                end
                default:  ;
            endcase
        end
        if (step) begin
            if (roll) ptr_n = ptr + (PW+1)'(1);
            else      ptr_n = {ptr[PW], ptr[PW-1:0] + PW'(1)};
        end
    end

    a_r4_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> ptr == '0);

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && bus_cs && !bus_cmd) |=> ($stable(ptr) && state == ST_IDLE));

    a_r6_wrap_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_fire && state == ST_WRBUF && data_wr && !roll && ptr[PW-1:0] == {PW{1'b1}})
        |=> (ptr[PW-1:0] == '0 && ptr[PW] == $past(ptr[PW])));

    a_r7_dma_roll: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_fire && state == ST_WRBUF && data_wr && roll && ptr == LAST_PRI)
        |=> ptr == FIRST_SEC);

    a_r9_stat_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> state == ST_IDLE);

endmodule

// File: rtl/epb_store.sv
module epb_store #(
    parameter int NUM_EP = 16,
    parameter int HALF_WORDS = 32,
    localparam int EW = $clog2(NUM_EP),
    localparam int PW = $clog2(HALF_WORDS),
    localparam int AW = EW + PW + 1,
    localparam int DEPTH = NUM_EP * 2 * HALF_WORDS
) (
    input  logic          clk,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wd,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [15:0]   fill_wd,
    input  logic [AW-1:0] rda_addr,
    output logic [15:0]   rda_data,
    input  logic [AW-1:0] rdb_addr,
    output logic [15:0]   rdb_data
);

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (fill_we) mem[fill_addr] <= fill_wd;
        if (bus_we)  mem[bus_addr]  <= bus_wd;
    end

    assign rda_data = mem[rda_addr];
    assign rdb_data = mem[rdb_addr];

endmodule

// File: rtl/epb_flags.sv
module epb_flags
    import epb_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter logic [NUM_EP-1:0] DBL_MASK = '0,
    localparam int EW = $clog2(NUM_EP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_done,
    input  logic          fill_ok,
    input  logic [EW-1:0] fill_ep,
    input  logic          stat_rd,
    input  logic [EW-1:0] sel_ep,
    input  logic          stall_set,
    input  logic          stall_clr,
    input  logic [EW-1:0] cmd_ep,
    input  logic          setup_rx,
    input  logic [EW-1:0] setup_ep,
    output logic [15:0]   status,
    output logic          irq
);

    logic [NUM_EP-1:0] int_q, stall_q, setup_q;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic int_b, stall_b, setup_b;
        logic hit_fill, hit_stat, hit_setup, hit_cmd;

        assign hit_fill  = fill_done && fill_ok && fill_ep == EW'(i);
        assign hit_stat  = stat_rd && sel_ep == EW'(i);
        assign hit_setup = setup_rx && setup_ep == EW'(i);
        assign hit_cmd   = cmd_ep == EW'(i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                int_b   <= 1'b0;
                stall_b <= 1'b0;
                setup_b <= 1'b0;
            end else begin
                if (hit_fill)      int_b <= 1'b1;
                else if (hit_stat) int_b <= 1'b0;
                if (hit_setup)     setup_b <= 1'b1;
                else if (hit_stat) setup_b <= 1'b0;
                if (hit_setup)                 stall_b <= 1'b0;
                else if (stall_set && hit_cmd) stall_b <= 1'b1;
                else if (stall_clr && hit_cmd) stall_b <= 1'b0;
            end
        end

        assign int_q[i]   = int_b;
        assign stall_q[i] = stall_b;
        assign setup_q[i] = setup_b;
    end

    always_comb begin
        status           = '0;
        status[SB_INT]   = int_q[sel_ep];
        status[SB_STALL] = stall_q[sel_ep];
        status[SB_SETUP] = setup_q[sel_ep];
        status[SB_DBL]   = DBL_MASK[sel_ep];
    end

    assign irq = |int_q;

    a_r8_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && fill_ok) |=> int_q[$past(fill_ep)]);

    a_r9_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(fill_done && fill_ok && fill_ep == sel_ep)) |=> !int_q[$past(sel_ep)]);

    a_r10_setup_unstall: assert property (@(posedge clk) disable iff (!rst_n)
        setup_rx |=> (!stall_q[$past(setup_ep)] && setup_q[$past(setup_ep)]));

endmodule

// File: rtl/epb_bank.sv
module epb_bank
    import epb_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int HALF_WORDS = 32,
    parameter logic [NUM_EP-1:0] DBL_MASK = 16'h000C,
    localparam int EW = $clog2(NUM_EP),
    localparam int PW = $clog2(HALF_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_cmd,
    input  logic          bus_wr,
    input  logic          bus_dma,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic          fill_we,
    input  logic [EW-1:0] fill_ep,
    input  logic [PW:0]   fill_idx,
    input  logic [15:0]   fill_wdata,
    input  logic          fill_done,
    input  logic          fill_ok,
    input  logic [EW-1:0] drn_ep,
    input  logic [PW:0]   drn_idx,
    output logic [15:0]   drn_rdata,
    input  logic          setup_rx,
    input  logic [EW-1:0] setup_ep,
    output logic          irq
);

    epb_state_e    state;
    logic [EW-1:0] sel_ep, cmd_ep;
    logic [PW:0]   ptr;
    logic          mem_we, stat_rd, stall_set, stall_clr;
    logic [15:0]   buf_word, status;
    logic          rd_cycle;

    epb_cmd_fsm #(.NUM_EP(NUM_EP), .HALF_WORDS(HALF_WORDS), .DBL_MASK(DBL_MASK)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .bus_cs(bus_cs), .bus_cmd(bus_cmd), .bus_wr(bus_wr), .bus_dma(bus_dma),
        .bus_wdata(bus_wdata),
        .state(state), .sel_ep(sel_ep), .ptr(ptr), .cmd_ep(cmd_ep),
        .mem_we(mem_we), .stat_rd(stat_rd), .stall_set(stall_set), .stall_clr(stall_clr)
    );

    epb_store #(.NUM_EP(NUM_EP), .HALF_WORDS(HALF_WORDS)) u_store (
        .clk(clk),
        .bus_we(mem_we), .bus_addr({sel_ep, ptr}), .bus_wd(bus_wdata),
        .fill_we(fill_we), .fill_addr({fill_ep, fill_idx}), .fill_wd(fill_wdata),
        .rda_addr({sel_ep, ptr}), .rda_data(buf_word),
        .rdb_addr({drn_ep, drn_idx}), .rdb_data(drn_rdata)
    );

    epb_flags #(.NUM_EP(NUM_EP), .DBL_MASK(DBL_MASK)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .fill_done(fill_done), .fill_ok(fill_ok), .fill_ep(fill_ep),
        .stat_rd(stat_rd), .sel_ep(sel_ep),
        .stall_set(stall_set), .stall_clr(stall_clr), .cmd_ep(cmd_ep),
        .setup_rx(setup_rx), .setup_ep(setup_ep),
        .status(status), .irq(irq)
    );

    assign rd_cycle = bus_cs & ~bus_cmd & ~bus_wr;

    always_comb begin
        bus_rdata = '0;
        if (rd_cycle) begin
            unique case (state)
                ST_RDBUF: bus_rdata = buf_word;
                ST_STAT:  bus_rdata = status;
                default:  bus_rdata = '0;
            endcase
        end
    end

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WRBUF) |-> bus_rdata == 16'h0);

endmodule

// File: tb/sim_epb_bank.sv
module sim_epb_bank;

    localparam int NUM_EP = 16;
    localparam int HALF = 32;
    localparam int EW = 4;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs = 0, bus_cmd = 0, bus_wr = 0, bus_dma = 0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          fill_we = 0, fill_done = 0, fill_ok = 0, setup_rx = 0;
    logic [EW-1:0] fill_ep = '0, drn_ep = '0, setup_ep = '0;
    logic [PW:0]   fill_idx = '0, drn_idx = '0;
    logic [15:0]   fill_wdata = '0;
    logic [15:0]   drn_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    epb_bank #(.NUM_EP(NUM_EP), .HALF_WORDS(HALF), .DBL_MASK(16'h000C)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_cs(bus_cs), .bus_cmd(bus_cmd), .bus_wr(bus_wr), .bus_dma(bus_dma),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fill_we(fill_we), .fill_ep(fill_ep), .fill_idx(fill_idx), .fill_wdata(fill_wdata),
        .fill_done(fill_done), .fill_ok(fill_ok),
        .drn_ep(drn_ep), .drn_idx(drn_idx), .drn_rdata(drn_rdata),
        .setup_rx(setup_rx), .setup_ep(setup_ep), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bcyc(input logic c, input logic w, input logic [15:0] d,
                        input logic dma, output logic [15:0] q);
        @(negedge clk);
        bus_cs = 1; bus_cmd = c; bus_wr = w; bus_wdata = d; bus_dma = dma;
        #1 q = bus_rdata;
        @(posedge clk);
        #1 bus_cs = 0; bus_cmd = 0; bus_wr = 0; bus_dma = 0;
    endtask

    task automatic cmd(input logic [15:0] code);
        logic [15:0] q;
        bcyc(1'b1, 1'b1, code, 1'b0, q);
    endtask

    task automatic wrd(input logic [15:0] d, input logic dma);
        logic [15:0] q;
        bcyc(1'b0, 1'b1, d, dma, q);
    endtask

    task automatic rdd(output logic [15:0] q);
        bcyc(1'b0, 1'b0, 16'h0, 1'b0, q);
    endtask

    task automatic drn(input int ep, input int idx, output logic [15:0] q);
        @(negedge clk);
        drn_ep = EW'(ep); drn_idx = (PW+1)'(idx);
        #1 q = drn_rdata;
    endtask

    task automatic fillw(input int ep, input int idx, input logic [15:0] d);
        @(negedge clk);
        fill_we = 1; fill_ep = EW'(ep); fill_idx = (PW+1)'(idx); fill_wdata = d;
        @(posedge clk);
        #1 fill_we = 0;
    endtask

    task automatic fdone(input int ep, input logic ok);
        @(negedge clk);
        fill_done = 1; fill_ok = ok; fill_ep = EW'(ep);
        @(posedge clk);
        #1 fill_done = 0; fill_ok = 0;
    endtask

    function automatic logic [15:0] pack(input logic [7:0] b [64], input int n, input int k);
        logic [7:0] lo, hi;
        lo = (2*k-2 < n) ? b[2*k-2] : 8'h00;
        hi = (2*k-1 < n) ? b[2*k-1] : 8'h00;
        return {hi, lo};
    endfunction

    function automatic int nwords(input int n);
        return (n + 1) / 2;
    endfunction

    initial begin
        logic [15:0] q;
        logic [7:0]  by [64];
        int unsigned junk;
        junk = $urandom(32'h5EED);

        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R12: reset state
        chk("R12 irq after reset", {15'h0, irq}, 16'h0);
        cmd(16'h0053);
        rdd(q);
        chk("R12/R9 status ep3 after reset", q, 16'h0008);
        cmd(16'h0050);
        rdd(q);
        chk("R12 status ep0 after reset", q, 16'h0000);
        rdd(q);
        chk("R9 idle after status read", q, 16'h0000);

        // R2 R3: odd-length packet on ep5
        by[0] = 8'h11; by[1] = 8'h22; by[2] = 8'h33; by[3] = 8'h44; by[4] = 8'h55;
        cmd(16'h0005);
        wrd(16'd5, 1'b0);
        for (int k = 1; k <= nwords(5); k++) wrd(pack(by, 5, k), 1'b0);
        drn(5, 0, q); chk("R2 length word at index 0", q, 16'd5);
        drn(5, 1, q); chk("R3 first payload word byte order", q, 16'h2211);
        drn(5, 3, q); chk("R3 odd tail upper half unused", q, 16'h0055);

        // R4 R1: pointer home on each command, upper byte ignored
        cmd(16'h0015);
        rdd(q); chk("R2 bus read length", q, 16'd5);
        rdd(q); chk("R13 bus read payload", q, 16'h2211);
        cmd(16'hAB15);
        rdd(q); chk("R4 pointer home after new command", q, 16'd5);
        chk("R1 upper byte ignored", q, 16'd5);

        // R5: data cycles with no valid command
        cmd(16'h0033);
        wrd(16'hDEAD, 1'b0);
        rdd(q); chk("R5 idle read returns 0", q, 16'h0);
        drn(5, 0, q); chk("R5 idle write changed nothing", q, 16'd5);
        cmd(16'h0005);
        rdd(q); chk("R5 read in write state returns 0", q, 16'h0);
        wrd(16'h0007, 1'b0);
        drn(5, 0, q); chk("R5 wrong-direction read did not move pointer", q, 16'h0007);

        // R6: wrap inside one half, single-buffered ep6 and DMA on single ep7
        cmd(16'h0006);
        for (int i = 0; i <= HALF; i++) wrd(16'h6000 + 16'(i), 1'b0);
        drn(6, 0, q);  chk("R6 overrun wraps to index 0", q, 16'h6000 + 16'(HALF));
        drn(6, HALF - 1, q); chk("R6 last word of half", q, 16'h6000 + 16'(HALF - 1));
        cmd(16'h0007);
        for (int i = 0; i <= HALF; i++) wrd(16'h7000 + 16'(i), 1'b1);
        drn(7, 0, q); chk("R6 DMA on single buffer still wraps", q, 16'h7000 + 16'(HALF));
        cmd(16'h0002);
        for (int i = 0; i <= HALF; i++) wrd(16'h2000 + 16'(i), 1'b0);
        drn(2, 0, q); chk("R6 non-DMA on double buffer wraps in half", q, 16'h2000 + 16'(HALF));

        // R7: DMA rollover on double-buffered ep3
        cmd(16'h0003);
        for (int i = 0; i <= HALF; i++) wrd(16'h3000 + 16'(i), 1'b1);
        drn(3, HALF, q); chk("R7 rollover into secondary", q, 16'h3000 + 16'(HALF));
        drn(3, 0, q);    chk("R7 primary index 0 intact", q, 16'h3000);
        for (int i = HALF + 1; i <= 2 * HALF; i++) wrd(16'h3000 + 16'(i), 1'b1);
        drn(3, 0, q); chk("R7 secondary end wraps to primary", q, 16'h3000 + 16'(2 * HALF));

        // R8 R9 R11: fill port and flags
        fillw(9, 0, 16'd3);
        fillw(9, 1, 16'hBBAA);
        fillw(9, 2, 16'h00CC);
        fdone(9, 1'b0);
        chk("R8 errored packet no irq", {15'h0, irq}, 16'h0);
        fdone(9, 1'b1);
        chk("R11 irq after good packet", {15'h0, irq}, 16'h1);
        cmd(16'h0019);
        rdd(q); chk("R8 bus reads fill length", q, 16'd3);
        rdd(q); chk("R8 bus reads fill payload", q, 16'hBBAA);
        cmd(16'h0059);
        rdd(q); chk("R9 status shows flag", q, 16'h0001);
        chk("R11 irq clears with status read", {15'h0, irq}, 16'h0);
        rdd(q); chk("R9 second data read after status is idle", q, 16'h0);

        // R9: set wins over clear in the same cycle
        fdone(9, 1'b1);
        cmd(16'h0059);
        @(negedge clk);
        bus_cs = 1; bus_cmd = 0; bus_wr = 0;
        fill_done = 1; fill_ok = 1; fill_ep = 4'd9;
        @(posedge clk);
        #1 bus_cs = 0; fill_done = 0; fill_ok = 0;
        chk("R9 set wins over status clear", {15'h0, irq}, 16'h1);
        cmd(16'h0059);
        rdd(q);

        // R10: stall, unstall, setup
        cmd(16'h0044);
        cmd(16'h0054); rdd(q); chk("R10 stall set", q, 16'h0002);
        cmd(16'h0084);
        cmd(16'h0054); rdd(q); chk("R10 unstall clears", q, 16'h0000);
        cmd(16'h0044);
        @(negedge clk); setup_rx = 1; setup_ep = 4'd4;
        @(posedge clk); #1 setup_rx = 0;
        cmd(16'h0054); rdd(q); chk("R10 setup clears stall sets setup", q, 16'h0004);
        cmd(16'h0054); rdd(q); chk("R9 setup bit cleared by status read", q, 16'h0000);

        // random bus-written packets checked through the drain port
        for (int it = 0; it < 40; it++) begin
            int ep, n;
            ep = int'($urandom_range(0, 15));
            n  = int'($urandom_range(0, 32));
            for (int j = 0; j < 64; j++) by[j] = 8'($urandom);
            cmd({8'($urandom), 4'h0, 4'(ep)});
            wrd(16'(n), 1'b0);
            for (int k = 1; k <= nwords(n); k++) wrd(pack(by, n, k), 1'b0);
            drn(ep, 0, q); chk("R2 random length", q, 16'(n));
            for (int k = 1; k <= nwords(n); k++) begin
                drn(ep, k, q); chk("R3 random payload", q, pack(by, n, k));
            end
        end

        // random fill-port packets checked through the bus
        for (int it = 0; it < 30; it++) begin
            int ep, n;
            ep = int'($urandom_range(0, 15));
            n  = int'($urandom_range(1, 32));
            for (int j = 0; j < 64; j++) by[j] = 8'($urandom);
            fillw(ep, 0, 16'(n));
            for (int k = 1; k <= nwords(n); k++) fillw(ep, k, pack(by, n, k));
            fdone(ep, 1'b1);
            chk("R11 random irq", {15'h0, irq}, 16'h1);
            cmd({8'h00, 4'h1, 4'(ep)});
            rdd(q); chk("R2 random fill length", q, 16'(n));
            for (int k = 1; k <= nwords(n); k++) begin
                rdd(q); chk("R13 random fill payload", q, pack(by, n, k));
            end
            cmd({8'h00, 4'h5, 4'(ep)});
            rdd(q); chk("R9 random status", q & 16'h0001, 16'h0001);
            chk("R8 flag cleared", {15'h0, irq}, 16'h0);
        end

        done = 1;
        summary();
    end

endmodule